// File: doc/BRIEF.md
# Debounced Keypad Digit Encoder

This block sits between twelve raw key lines of a 3x4 keypad and the logic that consumes keyed digits. Every key owns one active-high line. Each line first crosses a two-flop synchroniser. It then passes through its own filter, which takes on a new level only after that level has held for a set number of sample ticks. The twelve filtered lines feed an encoder. When exactly one digit key is held, the encoder drives the digit's binary value and raises a press flag.

The outputs are plain registered levels, not a stream. They carry no valid/ready handshake and never apply back-pressure: a consumer watches the press flag and may take the code on any cycle in which the flag is high. One free-running divider produces a single sample tick, and all twelve filters share it. `TICK_DIV` sets the tick spacing in clocks. `STABLE_TICKS` sets the run length a filter needs before it accepts a change. The defaults give a 1 ms tick and a 10 ms settle time at a 50 MHz clock.

Top module: `kp_encoder_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `key_code` is 0000 and `key_press` is 0. Every filtered line starts in the released state.
- R2: A change on a raw line reaches the outputs only after the synchronised level has differed from the filtered level on `STABLE_TICKS` consecutive sample ticks. A pulse covering fewer ticks never shows at the outputs. Between ticks, a filtered level does not change.
- R3: The key lines map to digits as follows: bit 0 = 3, bit 1 = 6, bit 2 = 9, bit 4 = 2, bit 5 = 5, bit 6 = 8, bit 8 = 1, bit 9 = 4, bit 10 = 7. When one of these keys is the only key held, `key_code` is that digit in 4-bit binary.
- R4: If no line, or two or more lines, are held after filtering, `key_code` is 0000 and `key_press` is 0.
- R5: Bit 11 (star) and bit 3 (hash) are not digits. When either one is held, `key_code` is 0000 and `key_press` is 0.
- R6: `key_press` stays 1 for as long as a single digit key stays held. It returns to 0 once the release has passed the filter. Whenever `key_press` is 0, `key_code` is 0000.
- R7: The zero key on bit 7 gives `key_code` 0000 with `key_press` 1.
- R8: The lines are filtered independently. A short glitch on one line leaves a steadily held key's code and press flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_raw | input | 12 | Raw key lines, one per key, active high |
| key_code | output | 4 | Binary value of the held digit key, 0000 otherwise |
| key_press | output | 1 | High while exactly one digit key is held after filtering |

## Verification
The embedded assertions take several things for granted. Reset is applied before the first tick. The sample tick comes only from the internal divider. The raw lines are plain levels that may change on any clock. The bench drives `key_raw` only on falling edges and holds every stimulus either clearly longer than the settle window or clearly shorter than it. This keeps every check outside the band of one tick's phase uncertainty. It samples only at settled points, or at a point just before the earliest legal acceptance.

// File: rtl/kp_pkg.sv
package kp_pkg;

  localparam int KEY_COUNT = 12;
  localparam int CODE_W    = 4;
  localparam int IDX_STAR  = 11;
  localparam int IDX_HASH  = 3;

  // digit carried by each key line; non-digit keys return zero
  function automatic logic [CODE_W-1:0] line_digit(input int idx);
    logic [CODE_W-1:0] d;
    case (idx)
      0:       d = 4'd3;
      1:       d = 4'd6;
      2:       d = 4'd9;
      4:       d = 4'd2;
      5:       d = 4'd5;
      6:       d = 4'd8;
      7:       d = 4'd0;
      8:       d = 4'd1;
      9:       d = 4'd4;
      10:      d = 4'd7;
      default: d = 4'd0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/kp_tick_gen.sv
module kp_tick_gen #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(TICK_DIV - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = (cnt_q == CW'(TICK_DIV - 1));

      // R2: ticks are isolated pulses, never back to back
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/kp_debounce_bit.sv
module kp_debounce_bit #(
  parameter int STABLE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int CNTW = $clog2(STABLE_TICKS + 1);
  localparam logic [CNTW-1:0] LIM = CNTW'(STABLE_TICKS - 1);

  logic            meta_q, sync_q;
  logic            level_q;
  logic [CNTW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (tick) begin
      if (sync_q != level_q) begin
        if (run_q == LIM) begin
          level_q <= sync_q;
          run_q   <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level = level_q;

  // R2: filtered level only moves on a sample tick
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q));

  // R2: a new level always equals the synchronised input it came from
  assert_follow_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sync_q != level_q && run_q == LIM) |=> (level_q == $past(sync_q)));

endmodule

// File: rtl/kp_onehot_encode.sv
module kp_onehot_encode
  import kp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KEY_COUNT-1:0] deb,
  output logic [CODE_W-1:0]    code,
  output logic                 press
);
  logic [CODE_W-1:0] code_acc;
  logic              single;
  logic              digit_ok;
  logic [CODE_W-1:0] code_q;
  logic              press_q;

  always_comb begin
    code_acc = '0;
    for (int i = 0; i < KEY_COUNT; i++) begin
      if (deb[i]) code_acc = code_acc | line_digit(i);
    end
  end

  assign single   = ($countones(deb) == 1);
  assign digit_ok = single && !deb[IDX_STAR] && !deb[IDX_HASH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      press_q <= 1'b0;
    end else begin
      code_q  <= digit_ok ? code_acc : '0;
      press_q <= digit_ok;
    end
  end

  assign code  = code_q;
  assign press = press_q;

  // R4: no press unless exactly one line was held
  assert_single_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(deb) != 1) |=> !press);

  // R5: star or hash never yields a press
  assert_no_symbol_press_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (deb[IDX_STAR] || deb[IDX_HASH]) |=> !press);

  // R6: idle code is zero
  assert_idle_code_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !press |-> (code == '0));

  // R7: zero key yields press with code zero
  assert_zero_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (deb == 12'h080) |=> (press && code == '0));

endmodule

// File: rtl/kp_encoder_top.sv
module kp_encoder_top
  import kp_pkg::*;
#(
  parameter int TICK_DIV     = 50000,
  parameter int STABLE_TICKS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] key_raw,
  output logic [3:0]  key_code,
  output logic        key_press
);
  logic                 tick;
  logic [KEY_COUNT-1:0] deb;

  kp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  generate
    for (genvar g = 0; g < KEY_COUNT; g++) begin : g_line
      kp_debounce_bit #(.STABLE_TICKS(STABLE_TICKS)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .raw   (key_raw[g]),
        .level (deb[g])
      );
    end
  endgenerate

  kp_onehot_encode u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .deb   (deb),
    .code  (key_code),
    .press (key_press)
  );

  // R1: nothing is pressed in the cycle reset is released
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!key_press && key_code == 4'd0));

endmodule

// File: tb/test_kp_encoder_top.sv
module test_kp_encoder_top;
  localparam int DIV    = 4;
  localparam int N      = 3;
  localparam int SETTLE = (N + 2) * DIV + 6;
  localparam int EARLY  = (N - 1) * DIV;
  localparam int GLITCH = (N - 1) * DIV - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] key_raw = '0;
  logic [3:0]  key_code;
  logic        key_press;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  kp_encoder_top #(.TICK_DIV(DIV), .STABLE_TICKS(N)) i_kp_encoder_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_raw   (key_raw),
    .key_code  (key_code),
    .key_press (key_press)
  );

  // expected digit per line, taken from R3 / R5 / R7
  function automatic int exp_digit(input int b);
    case (b)
      0: return 3;  1: return 6;  2: return 9;  4: return 2;
      5: return 5;  6: return 8;  7: return 0;  8: return 1;
      9: return 4;  10: return 7; default: return -1;
    endcase
  endfunction

  task automatic check(input string req, input int act_code, input int act_press,
                       input int exp_code, input int exp_press);
    checks++;
    if (act_code != exp_code || act_press != exp_press) begin
      errors++;
      $display("FAIL %s: code=%0d press=%0d expected code=%0d press=%0d",
               req, act_code, act_press, exp_code, exp_press);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_settle(input logic [11:0] v);
    @(negedge clk);
    key_raw = v;
    wait_cyc(SETTLE);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    key_raw = 12'h010;
    wait_cyc(5);
    check("R1 during reset", key_code, key_press, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    key_raw = '0;
    wait_cyc(2);
    check("R1 after reset", key_code, key_press, 0, 0);
    drive_settle('0);
  endtask

  task automatic t_all_keys;
    for (int b = 0; b < 12; b++) begin
      drive_settle(12'(1) << b);
      if (exp_digit(b) < 0)
        check($sformatf("R5 symbol line %0d", b), key_code, key_press, 0, 0);
      else if (b == 7)
        check("R7 zero key", key_code, key_press, 0, 1);
      else
        check($sformatf("R3 line %0d", b), key_code, key_press, exp_digit(b), 1);
      drive_settle('0);
      check("R6 release", key_code, key_press, 0, 0);
    end
  endtask

  task automatic t_multi;
    drive_settle(12'h011);
    check("R4 two digits", key_code, key_press, 0, 0);
    drive_settle(12'h808);
    check("R4 star and hash", key_code, key_press, 0, 0);
    drive_settle(12'hFFF);
    check("R4 all lines", key_code, key_press, 0, 0);
    drive_settle('0);
    check("R4 none", key_code, key_press, 0, 0);
  endtask

  task automatic t_hold;
    drive_settle(12'h400);
    for (int k = 0; k < 4; k++) begin
      wait_cyc(SETTLE);
      check("R6 held key", key_code, key_press, 7, 1);
    end
    drive_settle('0);
  endtask

  task automatic t_early;
    int bad = 0;
    @(negedge clk);
    key_raw = 12'h004;
    for (int k = 0; k < EARLY; k++) begin
      @(negedge clk);
      if (key_press !== 1'b0) bad++;
    end
    check("R2 no early accept", bad, 0, 0, 0);
    wait_cyc(SETTLE);
    check("R2 accepted after run", key_code, key_press, 9, 1);
    drive_settle('0);
  endtask

  task automatic t_glitch;
    int bad = 0;
    @(negedge clk);
    key_raw = 12'h020;
    for (int k = 0; k < GLITCH; k++) begin
      @(negedge clk);
      if (key_press !== 1'b0) bad++;
    end
    key_raw = '0;
    for (int k = 0; k < SETTLE; k++) begin
      @(negedge clk);
      if (key_press !== 1'b0) bad++;
    end
    check("R2 short pulse rejected", bad, 0, 0, 0);
  endtask

  task automatic t_independent;
    int bad = 0;
    drive_settle(12'h020);
    @(negedge clk);
    key_raw = 12'h030;
    for (int k = 0; k < GLITCH; k++) begin
      @(negedge clk);
      if (key_code != 4'd5 || key_press != 1'b1) bad++;
    end
    key_raw = 12'h020;
    for (int k = 0; k < SETTLE; k++) begin
      @(negedge clk);
      if (key_code != 4'd5 || key_press != 1'b1) bad++;
    end
    check("R8 other line glitch ignored", bad, 0, 0, 0);
    check("R8 held key kept", key_code, key_press, 5, 1);
    drive_settle('0);
  endtask

  initial begin
    t_reset();
    t_all_keys();
    t_multi();
    t_hold();
    t_early();
    t_glitch();
    t_independent();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule